// File: doc/BRIEF.md
# MSI-X Capability Control Register

This block holds the configuration-space MSI-X capability structure of one PCI function: a control word that carries the table size and the two writable control flags, plus two read-only locator dwords that give the BAR and offset of the vector table and of the pending-bit array. The host reaches it through a byte-addressed configuration port. Reads are combinational and return the whole dword that contains the addressed byte. Only a 2-byte write at capability offset 2 changes state. Any other write is rejected and flagged.

The current enable and function-mask flags go straight out to the companion vector block. That block owns the vector table, the pending bits and message generation. Changes of the flags are reported to it as single-cycle event pulses, registered on the same clock edge that updates the flags:
- A rising enable asks for routing setup of all vectors. A failed setup drops enable again.
- A rising mask is reported on its own pulse.
- A falling mask asks for a scan of all pending vectors. If the companion is still busy with an earlier scan, the request is held until that scan ends.

Top module: `msix_cap_ctl`

## Requirements
- R1: After reset `en_o` and `fmask_o` are 0, and `route_req_o`, `mask_rise_o`, `scan_req_o`, `chg_o` and `cfg_err_o` are 0.
- R2: A write is accepted only when `cfg_len_i` is 2 and `cfg_addr_i` is 2. The enable flag is then taken from `cfg_wdata_i[15]` and the mask flag from `cfg_wdata_i[14]`. Any other write pulses `cfg_err_o` for one cycle after the write edge and leaves `en_o` and `fmask_o` unchanged.
- R3: A read of any byte address in dword 0 (addresses 0 to 3) returns the following; the value does not depend on which byte is addressed:
  - bit 31: the enable flag;
  - bit 30: the mask flag;
  - bits 29:27: zero;
  - bits 26:16: `NUM_VEC-1`;
  - bits 15:0: zero.
- R4: Dword 1 (addresses 4 to 7) returns the table locator and dword 2 (addresses 8 to 11) returns the pending-array locator. Each locator is `{OFF[31:3], BIR[2:0]}`, so the offset's low three bits always read 0. Any higher dword reads 0.
- R5: `route_req_o` pulses for exactly one cycle, on the edge where an accepted write takes enable from 0 to 1. A write that leaves enable at 1 gives no pulse.
- R6: While a routing setup is outstanding (from `route_req_o` until `route_done_i`), `route_done_i` with `route_fail_i` clears enable on the next edge. A successful done keeps enable. An accepted write in the same cycle takes priority over the failure.
- R7: `mask_rise_o` pulses for one cycle on the edge where an accepted write takes the mask from 0 to 1.
- R8: A mask fall from 1 to 0 gives one `scan_req_o` pulse:
  - on the write edge, if `scan_busy_i` is low in that cycle;
  - otherwise, on the first edge at which `scan_busy_i` is sampled low.
- R9: `chg_o` pulses for one cycle on each accepted write that changes the mask in either direction, and stays low for every other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Byte address within the capability |
| cfg_len_i | input | 3 | Byte count of the write (1, 2 or 4) |
| cfg_wdata_i | input | 16 | Write data, low two bytes |
| cfg_rdata_o | output | 32 | Dword containing the addressed byte |
| cfg_err_o | output | 1 | Pulse: rejected write |
| en_o | output | 1 | Function enable flag |
| fmask_o | output | 1 | Function mask flag |
| route_req_o | output | 1 | Pulse: route setup request |
| route_done_i | input | 1 | Route setup finished |
| route_fail_i | input | 1 | Route setup failed, valid with done |
| mask_rise_o | output | 1 | Pulse: mask set |
| scan_req_o | output | 1 | Pulse: scan pending vectors |
| scan_busy_i | input | 1 | Companion scan in progress |
| chg_o | output | 1 | Pulse: mask changed status |

## Verification
Two functions can fall in the same cycle, and both are provoked on purpose.
- A mask-fall write lands in the cycle where `scan_busy_i` drops. A mask-fall write is also issued while a busy scan is held, so the held request and the fresh fall merge. The expected result is exactly one `scan_req_o` pulse, on the first edge with busy sampled low.
- A routing failure arrives in the same cycle as an accepted write that re-asserts enable. The expected result is that the write wins and enable stays set.

A cycle model in the bench predicts both cases and is compared on every cycle of directed and random traffic.

// File: rtl/msix_ctl_pkg.sv
package msix_ctl_pkg;
  localparam int MAX_VEC  = 2048;
  localparam int EN_BIT   = 15;
  localparam int MASK_BIT = 14;
  localparam int CTL_OFF  = 2;
  localparam int CTL_LEN  = 2;
  localparam int SIZE_W   = 11;

  typedef enum logic [1:0] {
    DW_CTL = 2'd0,
    DW_TBL = 2'd1,
    DW_PBA = 2'd2,
    DW_NONE = 2'd3
  } dw_sel_e;

  function automatic logic [31:0] locator(input logic [31:0] off, input logic [2:0] bir);
    return {off[31:3], bir};
  endfunction
endpackage

// File: rtl/msix_ctl_wdec.sv
module msix_ctl_wdec
  import msix_ctl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        len_i,
  input  logic [15:0]       wdata_i,
  output logic              ok_o,
  output logic              bad_o,
  output logic              new_en_o,
  output logic              new_mask_o
);
  logic hit;
  logic unused_wd;

  assign hit        = (addr_i == ADDR_W'(CTL_OFF)) && (len_i == 3'(CTL_LEN));
  assign ok_o       = wr_i & hit;
  assign bad_o      = wr_i & ~hit;
  assign new_en_o   = wdata_i[EN_BIT];
  assign new_mask_o = wdata_i[MASK_BIT];
  assign unused_wd  = ^wdata_i[13:0];
endmodule

// File: rtl/msix_ctl_state.sv
module msix_ctl_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  input  logic new_en_i,
  input  logic new_mask_i,
  input  logic route_done_i,
  input  logic route_fail_i,
  output logic en_o,
  output logic mask_o
);
  logic en_q, mask_q, busy_q;
  logic en_d, mask_d, busy_d;
  logic rise_en, fail_clr;

  assign rise_en  = ok_i & new_en_i & ~en_q;
  // accepted write outranks a coincident failure
  assign fail_clr = busy_q & route_done_i & route_fail_i & ~ok_i;

  always_comb begin
    en_d   = ok_i ? new_en_i : (fail_clr ? 1'b0 : en_q);
    mask_d = ok_i ? new_mask_i : mask_q;
    busy_d = rise_en ? 1'b1 : (route_done_i ? 1'b0 : busy_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
      busy_q <= busy_d;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/msix_ctl_evt.sv
module msix_ctl_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  input  logic bad_i,
  input  logic new_en_i,
  input  logic new_mask_i,
  input  logic en_i,
  input  logic mask_i,
  input  logic scan_busy_i,
  output logic err_o,
  output logic route_req_o,
  output logic mask_rise_o,
  output logic scan_req_o,
  output logic chg_o
);
  logic en_rise, m_rise, m_fall, want;
  logic err_q, req_q, mr_q, scan_q, chg_q, hold_q;

  assign en_rise = ok_i & new_en_i & ~en_i;
  assign m_rise  = ok_i & new_mask_i & ~mask_i;
  assign m_fall  = ok_i & ~new_mask_i & mask_i;
  assign want    = m_fall | hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      req_q  <= 1'b0;
      mr_q   <= 1'b0;
      scan_q <= 1'b0;
      chg_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      err_q  <= bad_i;
      req_q  <= en_rise;
      mr_q   <= m_rise;
      chg_q  <= m_rise | m_fall;
      scan_q <= want & ~scan_busy_i;
      hold_q <= want & scan_busy_i;
    end
  end

  assign err_o       = err_q;
  assign route_req_o = req_q;
  assign mask_rise_o = mr_q;
  assign scan_req_o  = scan_q;
  assign chg_o       = chg_q;
endmodule

// File: rtl/msix_ctl_rdmux.sv
module msix_ctl_rdmux
  import msix_ctl_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          NUM_VEC = 64,
  parameter logic [2:0]  TBL_BIR = 3'd2,
  parameter logic [31:0] TBL_OFF = 32'h0000_2000,
  parameter logic [2:0]  PBA_BIR = 3'd4,
  parameter logic [31:0] PBA_OFF = 32'h0000_3000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic              mask_i,
  output logic [31:0]       rdata_o
);
  localparam int NDW = 2 ** (ADDR_W - 2);
  localparam logic [SIZE_W-1:0] SIZE_ENC = SIZE_W'(NUM_VEC - 1);

  logic [31:0] dw [NDW];

  for (genvar g = 0; g < NDW; g++) begin : g_dw
    if (g == int'(DW_CTL)) begin : g_ctl
      assign dw[g] = {en_i, mask_i, 3'b000, SIZE_ENC, 16'h0000};
    end else if (g == int'(DW_TBL)) begin : g_tbl
      assign dw[g] = locator(TBL_OFF, TBL_BIR);
    end else if (g == int'(DW_PBA)) begin : g_pba
      assign dw[g] = locator(PBA_OFF, PBA_BIR);
    end else begin : g_zero
      assign dw[g] = 32'h0;
    end
  end

  assign rdata_o = dw[addr_i[ADDR_W-1:2]];
endmodule

// File: rtl/msix_cap_ctl.sv
module msix_cap_ctl
  import msix_ctl_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          NUM_VEC = 64,
  parameter logic [2:0]  TBL_BIR = 3'd2,
  parameter logic [31:0] TBL_OFF = 32'h0000_2004,
  parameter logic [2:0]  PBA_BIR = 3'd4,
  parameter logic [31:0] PBA_OFF = 32'h0000_300F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [2:0]        cfg_len_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              cfg_err_o,
  output logic              en_o,
  output logic              fmask_o,
  output logic              route_req_o,
  input  logic              route_done_i,
  input  logic              route_fail_i,
  output logic              mask_rise_o,
  output logic              scan_req_o,
  input  logic              scan_busy_i,
  output logic              chg_o
);
  logic ok, bad, new_en, new_mask, en_q, mask_q;

  msix_ctl_wdec #(.ADDR_W(ADDR_W)) u_wdec (
    .wr_i(cfg_wr_i), .addr_i(cfg_addr_i), .len_i(cfg_len_i), .wdata_i(cfg_wdata_i),
    .ok_o(ok), .bad_o(bad), .new_en_o(new_en), .new_mask_o(new_mask)
  );

  msix_ctl_state u_state (
    .clk_i(clk_i), .rst_ni(rst_ni), .ok_i(ok), .new_en_i(new_en), .new_mask_i(new_mask),
    .route_done_i(route_done_i), .route_fail_i(route_fail_i),
    .en_o(en_q), .mask_o(mask_q)
  );

  msix_ctl_evt u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ok_i(ok), .bad_i(bad), .new_en_i(new_en),
    .new_mask_i(new_mask), .en_i(en_q), .mask_i(mask_q), .scan_busy_i(scan_busy_i),
    .err_o(cfg_err_o), .route_req_o(route_req_o), .mask_rise_o(mask_rise_o),
    .scan_req_o(scan_req_o), .chg_o(chg_o)
  );

  msix_ctl_rdmux #(
    .ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC), .TBL_BIR(TBL_BIR), .TBL_OFF(TBL_OFF),
    .PBA_BIR(PBA_BIR), .PBA_OFF(PBA_OFF)
  ) u_rd (
    .addr_i(cfg_addr_i), .en_i(en_q), .mask_i(mask_q), .rdata_o(cfg_rdata_o)
  );

  assign en_o    = en_q;
  assign fmask_o = mask_q;
endmodule

// File: rtl/msix_cap_ctl_chk.sv
module msix_cap_ctl_chk #(
  parameter int ADDR_W  = 4,
  parameter int NUM_VEC = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_wr_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic [2:0]        cfg_len_i,
  input logic [31:0]       cfg_rdata_o,
  input logic              cfg_err_o,
  input logic              en_o,
  input logic              fmask_o,
  input logic              route_req_o,
  input logic              route_done_i,
  input logic              route_fail_i,
  input logic              mask_rise_o,
  input logic              scan_req_o,
  input logic              scan_busy_i,
  input logic              chg_o
);
  logic bad, outst_q;
  assign bad = cfg_wr_i && !(cfg_addr_i == ADDR_W'(2) && cfg_len_i == 3'd2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= 1'b0;
    else if (route_req_o) outst_q <= !route_done_i;
    else if (route_done_i) outst_q <= 1'b0;
  end

  p_bad_err_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> cfg_err_o);
  p_bad_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bad && !route_done_i) |=> ($stable(en_o) && $stable(fmask_o)));
  p_ctl_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_addr_i[ADDR_W-1:2] == '0) |-> (cfg_rdata_o[29:16] == {3'b000, 11'(NUM_VEC - 1)}));
  p_req_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_o) |-> route_req_o);
  p_req_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_req_o |=> !route_req_o);
  p_fail_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outst_q && !route_req_o && route_done_i && route_fail_i && !cfg_wr_i) |=> !en_o);
  p_mrise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fmask_o) |-> mask_rise_o);
  p_scan_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_req_o |-> !$past(scan_busy_i));
  p_chg_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> !$stable(fmask_o));
endmodule

bind msix_cap_ctl msix_cap_ctl_chk #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC)) u_chk (.*);

// File: tb/msix_cap_ctl_tb.sv
module msix_cap_ctl_tb_top;
  localparam int CLK_P = 10;
  localparam int ADDR_W = 4;
  localparam int NUM_VEC = 64;
  localparam logic [2:0]  TBL_BIR = 3'd2;
  localparam logic [31:0] TBL_OFF = 32'h0000_2004;
  localparam logic [2:0]  PBA_BIR = 3'd4;
  localparam logic [31:0] PBA_OFF = 32'h0000_300F;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, dn = 1'b0, fl = 1'b0, sb = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [2:0] len = 3'd0;
  logic [15:0] wd = '0;
  logic [31:0] rdata;
  logic err, en, fm, rreq, mrise, sreq, chg;

  int n_run = 0, n_fail = 0;
  // reference state
  logic m_en = 0, m_mask = 0, m_busy = 0, m_hold = 0;
  logic e_err = 0, e_req = 0, e_mr = 0, e_scan = 0, e_chg = 0;

  always #(CLK_P/2) clk = ~clk;

  msix_cap_ctl #(.ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC), .TBL_BIR(TBL_BIR), .TBL_OFF(TBL_OFF),
                 .PBA_BIR(PBA_BIR), .PBA_OFF(PBA_OFF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_len_i(len),
    .cfg_wdata_i(wd), .cfg_rdata_o(rdata), .cfg_err_o(err), .en_o(en), .fmask_o(fm),
    .route_req_o(rreq), .route_done_i(dn), .route_fail_i(fl), .mask_rise_o(mrise),
    .scan_req_o(sreq), .scan_busy_i(sb), .chg_o(chg)
  );

  function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] a, input logic e, input logic m);
    case (a[ADDR_W-1:2])
      0: return {e, m, 3'b000, 11'(NUM_VEC - 1), 16'h0000};
      1: return {TBL_OFF[31:3], TBL_BIR};
      2: return {PBA_OFF[31:3], PBA_BIR};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R6 en", 32'(en), 32'(m_en));
    check("R7 mask", 32'(fm), 32'(m_mask));
    check("R2 err", 32'(err), 32'(e_err));
    check("R5 route_req", 32'(rreq), 32'(e_req));
    check("R7 mask_rise", 32'(mrise), 32'(e_mr));
    check("R8 scan_req", 32'(sreq), 32'(e_scan));
    check("R9 chg", 32'(chg), 32'(e_chg));
    check(addr[ADDR_W-1:2] == 0 ? "R3 rdata" : "R4 rdata", rdata, exp_rd(addr, m_en, m_mask));
  endtask

  task automatic step(input logic w, input logic [ADDR_W-1:0] a, input logic [2:0] l,
                      input logic [15:0] d, input logic rd, input logic rf, input logic b);
    logic ok, rise, fall, want, fclr;
    wr = w; addr = a; len = l; wd = d; dn = rd; fl = rf; sb = b;
    ok   = w && a == ADDR_W'(2) && l == 3'd2;
    rise = ok && d[15] && !m_en;
    fall = ok && !d[14] && m_mask;
    fclr = m_busy && rd && rf && !ok;
    want = fall || m_hold;
    e_err = w && !ok;
    e_req = rise;
    e_mr  = ok && d[14] && !m_mask;
    e_chg = e_mr || fall;
    e_scan = want && !b;
    @(posedge clk); #1;
    m_hold = want && b;
    m_busy = rise ? 1'b1 : (rd ? 1'b0 : m_busy);
    m_en   = ok ? d[15] : (fclr ? 1'b0 : m_en);
    m_mask = ok ? d[14] : m_mask;
    compare_all();
  endtask

  task automatic cw(input logic e, input logic m, input logic rd, input logic rf, input logic b);
    step(1'b1, ADDR_W'(2), 3'd2, {e, m, 14'h2A5}, rd, rf, b);
  endtask

  task automatic idle(input logic rd, input logic rf, input logic b);
    step(1'b0, ADDR_W'(2), 3'd0, 16'h0, rd, rf, b);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_P * 3 + 1);
    // R1: reset state
    check("R1 en", 32'(en), 0); check("R1 mask", 32'(fm), 0);
    check("R1 pulses", 32'({err, rreq, mrise, sreq, chg}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare_all();
    // R2: rejected writes with flag bits set
    step(1'b1, ADDR_W'(0), 3'd4, 16'hFFFF, 0, 0, 0);
    step(1'b1, ADDR_W'(2), 3'd1, 16'hFFFF, 0, 0, 0);
    step(1'b1, ADDR_W'(3), 3'd2, 16'hFFFF, 0, 0, 0);
    // R4: locators, unaligned byte address
    for (int a = 0; a < 16; a++) step(1'b0, ADDR_W'(a), 3'd0, 16'h0, 0, 0, 0);
    // R5 R7 R9: enable and mask rise together
    cw(1, 1, 0, 0, 0);
    // R6: failure clears enable
    idle(1, 1, 0);
    idle(0, 0, 0);
    cw(1, 1, 0, 0, 0);
    idle(1, 0, 0);      // success keeps enable
    cw(1, 1, 0, 0, 0);  // R5: no pulse when already set
    // R8: fall while busy held then released
    cw(1, 0, 0, 0, 1);
    idle(0, 0, 1); idle(0, 0, 1); idle(0, 0, 0); idle(0, 0, 0);
    // R8: fall coinciding with busy drop
    cw(1, 1, 0, 0, 1);
    cw(1, 0, 0, 0, 0);
    // R8: held fall merged with a new fall
    cw(1, 1, 0, 0, 1); cw(1, 0, 0, 0, 1); cw(1, 1, 0, 0, 1); cw(1, 0, 0, 0, 1);
    idle(0, 0, 0);
    // R6: write outranks coincident failure
    cw(0, 0, 0, 0, 0); cw(1, 0, 0, 0, 0); cw(1, 1, 1, 1, 0); idle(1, 1, 0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic w, d, f, b, good;
      logic [ADDR_W-1:0] a;
      logic [2:0] l;
      w = ($urandom % 100) < 45;
      good = ($urandom % 100) < 75;
      a = good ? ADDR_W'(2) : ADDR_W'($urandom);
      l = good ? 3'd2 : 3'($urandom % 5);
      d = ($urandom % 100) < 12;
      f = ($urandom % 2) == 1;
      b = ($urandom % 100) < 40;
      step(w, a, l, 16'($urandom), d, f, b);
    end
    summary();
    $finish;
  end
endmodule